// File: doc/BRIEF.md
# Matrix Add/Multiply Accelerator

This block is a bus slave that computes with integer matrices held in its own local memory. One word-addressed window holds both the control registers (the first sixteen words) and a shared data memory (every word above them). Software places operand elements in the data memory in row-major order. It then fills three descriptors, each made of a pointer word and a shape word, and writes an operation code to the command register. The block checks the shapes and the memory extents. It runs either an element-wise sum or a matrix product on one sequential datapath and stores the result matrix in the same memory.

While the operation runs, the status register reads busy. Completion sets a done (or error) code and asserts an interrupt line. The line holds until software writes the status register. The matrix sizes are not built into the hardware: any shape whose elements fit in the data memory is accepted. Arithmetic wraps modulo 2^32.

Top module: `matop_engine`

## Requirements
- R1: After reset every register word reads 0, the status code is 0 (idle) and `irq` is low.
- R2: Register word indices are: 2n = pointer of matrix n and 2n+1 = shape of matrix n (n = 0..3; rows in bits [31:16], columns in bits [15:0]), 10 = command, 11 = status. While idle, words 0..7 and 10 read back what was written. Words 8, 9 and 12..15 always read 0 and ignore writes.
- R3: Read data for any word appears on `bus_rdata` one clock after the access. While idle, data-memory words (index 16 and up) are readable and writable.
- R4: Command codes are 0 = none (stored, with no other effect), 1 = add and 2 = multiply. Any other nonzero code ends at once with status 3 (error) and `irq`.
- R5: Add computes C[e] = A[e] + B[e] modulo 2^32 for every element. Matrix 0 is A, matrix 1 is B and matrix 2 is C. Pointers are word indices.
- R6: Multiply computes C[i][j] = sum over k of A[i][k]*B[k][j], modulo 2^32.
- R7: Add needs all three shapes equal. Multiply needs cols0 = rows1, rows2 = rows0 and cols2 = cols1. Any zero dimension or shape mismatch sets status 3 and `irq` at the command's clock edge.
- R8: Each of matrices 0..2 must satisfy pointer >= 16 and pointer + rows*cols <= window size. Otherwise the command ends with status 3 and `irq`. A matrix ending exactly at the top word is accepted.
- R9: An accepted command makes status read 1 (busy) from the next cycle. On completion, status becomes 2 (done) and `irq` rises on the same edge.
- R10: Done arrives exactly E*(3K+1) clocks after the command edge, where E = rows2*cols2, K = cols0 for multiply and K = 1 for add.
- R11: `irq` stays high until a status-register write while not busy. That write clears `irq` and returns the status to 0.
- R12: While busy, bus writes to any register or memory word are ignored, data-memory reads return 0, and register reads still work.
- R13: The matrix 3 descriptor is stored and read back but has no effect on either operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(WIN_WORDS) | Word index in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| irq | output | 1 | Completion interrupt, held until status is written |

## Verification
Every read is sampled on the falling edge that follows the clock edge capturing the request, because the read data register updates on that edge. Command-check errors land on the same edge as the command write, so the status read that directly follows must already show the error. For accepted commands the bench counts whole cycles from the command edge until `irq` is seen high. It compares that count with E*(3K+1), and only then reads the status and the result words. Checks made during a busy window are issued early in a long multiply, well before its computed completion cycle.

// File: rtl/matop_engine.sv
module matop_engine #(
  parameter int WIN_WORDS = 1024
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_we,
  input  logic [$clog2(WIN_WORDS)-1:0] bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         irq
);
  localparam int AW = $clog2(WIN_WORDS);
  localparam int REG_WORDS = 16;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2, ST_ERR = 2'd3;
  localparam logic [3:0] IX_CMD = 4'd10, IX_STAT = 4'd11;

  typedef enum logic [2:0] {E_IDLE, E_RDA, E_RDB, E_MAC, E_WR} eng_t;

  logic [7:0][31:0] dsc_q;
  logic [31:0]      cmd_q;
  logic [1:0]       st_q;
  logic             irq_q;

  eng_t             eng_q;
  logic             mul_q;
  logic [15:0]      md_q, nd_q, kd_q, i_q, j_q, k_q;
  logic [AW-1:0]    arow_q, aptr_q, bptr_q, bbase_q, cptr_q;
  logic [31:0]      opa_q, acc_q;

  logic [31:0]      mem [WIN_WORDS];
  logic [31:0]      m_rd, m_wd;
  logic [AW-1:0]    m_addr;
  logic             eng_we, bus_mem_we;
  logic             rd_mem_q;
  logic [31:0]      rd_reg_q, reg_val;

  wire       busy   = (st_q == ST_BUSY);
  wire       is_reg = (bus_addr < AW'(REG_WORDS));
  wire [3:0] ix     = bus_addr[3:0];
  wire       reg_wr = bus_sel && bus_we && is_reg && !busy;

  wire [15:0] r0 = dsc_q[1][31:16], c0 = dsc_q[1][15:0];
  wire [15:0] r1 = dsc_q[3][31:16], c1 = dsc_q[3][15:0];
  wire [15:0] r2 = dsc_q[5][31:16], c2 = dsc_q[5][15:0];

  function automatic logic fits(input logic [31:0] p, input logic [15:0] r, input logic [15:0] c);
    logic [47:0] stop;
    stop = 48'(p) + 48'(r) * 48'(c);
    return (r != 16'd0) && (c != 16'd0) && (p >= 32'(REG_WORDS)) && (stop <= 48'(WIN_WORDS));
  endfunction

  wire add_ok    = (r0 == r1) && (c0 == c1) && (r2 == r0) && (c2 == c0);
  wire mul_ok    = (c0 == r1) && (r2 == r0) && (c2 == c1);
  wire bounds_ok = fits(dsc_q[0], r0, c0) && fits(dsc_q[2], r1, c1) && fits(dsc_q[4], r2, c2);

  wire cmd_wr    = reg_wr && (ix == IX_CMD);
  wire op_add    = (bus_wdata == 32'd1);
  wire op_mul    = (bus_wdata == 32'd2);
  wire start_ok  = cmd_wr && bounds_ok && ((op_add && add_ok) || (op_mul && mul_ok));
  wire start_bad = cmd_wr && (bus_wdata != 32'd0) && !start_ok;

  wire last_k = !mul_q || (k_q == kd_q - 16'd1);
  wire last_j = (j_q == nd_q - 16'd1);
  wire last_i = (i_q == md_q - 16'd1);
  wire finish = (eng_q == E_WR) && last_i && last_j;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsc_q <= '0;
      cmd_q <= '0;
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        if (!ix[3]) dsc_q[ix[2:0]] <= bus_wdata;
        if (ix == IX_STAT) begin
          st_q  <= ST_IDLE;
          irq_q <= 1'b0;
        end
        if (cmd_wr) cmd_q <= bus_wdata;
      end
      if (start_ok) st_q <= ST_BUSY;
      if (start_bad) begin
        st_q  <= ST_ERR;
        irq_q <= 1'b1;
      end
      if (finish) begin
        st_q  <= ST_DONE;
        irq_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_q   <= E_IDLE;
      mul_q   <= 1'b0;
      md_q    <= '0;
      nd_q    <= '0;
      kd_q    <= '0;
      i_q     <= '0;
      j_q     <= '0;
      k_q     <= '0;
      arow_q  <= '0;
      aptr_q  <= '0;
      bptr_q  <= '0;
      bbase_q <= '0;
      cptr_q  <= '0;
      opa_q   <= '0;
      acc_q   <= '0;
    end else begin
      case (eng_q)
        E_IDLE: if (start_ok) begin
          mul_q   <= op_mul;
          md_q    <= r0;
          nd_q    <= op_mul ? c1 : c0;
          kd_q    <= op_mul ? c0 : 16'd1;
          i_q     <= '0;
          j_q     <= '0;
          k_q     <= '0;
          arow_q  <= AW'(dsc_q[0]);
          aptr_q  <= AW'(dsc_q[0]);
          bptr_q  <= AW'(dsc_q[2]);
          bbase_q <= AW'(dsc_q[2]);
          cptr_q  <= AW'(dsc_q[4]);
          acc_q   <= '0;
          eng_q   <= E_RDA;
        end
        E_RDA: eng_q <= E_RDB;
        E_RDB: begin
          opa_q <= m_rd;
          eng_q <= E_MAC;
        end
        E_MAC: begin
          acc_q <= mul_q ? acc_q + opa_q * m_rd : opa_q + m_rd;
          if (last_k) begin
            k_q   <= '0;
            eng_q <= E_WR;
          end else begin
            k_q    <= k_q + 16'd1;
            aptr_q <= aptr_q + 1'b1;
            bptr_q <= bptr_q + AW'(nd_q);
            eng_q  <= E_RDA;
          end
        end
        E_WR: begin
          acc_q  <= '0;
          cptr_q <= cptr_q + 1'b1;
          if (last_j) begin
            j_q <= '0;
            i_q <= i_q + 16'd1;
          end else begin
            j_q <= j_q + 16'd1;
          end
          if (!mul_q) begin
            aptr_q <= aptr_q + 1'b1;
            bptr_q <= bptr_q + 1'b1;
          end else if (last_j) begin
            arow_q <= arow_q + AW'(kd_q);
            aptr_q <= arow_q + AW'(kd_q);
            bptr_q <= bbase_q;
          end else begin
            aptr_q <= arow_q;
            bptr_q <= bbase_q + AW'(j_q) + 1'b1;
          end
          eng_q <= finish ? E_IDLE : E_RDA;
        end
        default: eng_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    case (eng_q)
      E_RDA:   m_addr = aptr_q;
      E_RDB:   m_addr = bptr_q;
      E_WR:    m_addr = cptr_q;
      default: m_addr = bus_addr;
    endcase
  end

  assign eng_we     = (eng_q == E_WR);
  assign bus_mem_we = bus_sel && bus_we && !is_reg && !busy;
  assign m_wd       = eng_we ? acc_q : bus_wdata;

  always_ff @(posedge clk) begin
    if (eng_we || bus_mem_we) mem[m_addr] <= m_wd;
    m_rd <= mem[m_addr];
  end

  always_comb begin
    reg_val = '0;
    if (!ix[3])             reg_val = dsc_q[ix[2:0]];
    else if (ix == IX_CMD)  reg_val = cmd_q;
    else if (ix == IX_STAT) reg_val = {30'd0, st_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mem_q <= 1'b0;
      rd_reg_q <= '0;
    end else begin
      rd_mem_q <= bus_sel && !bus_we && !is_reg && !busy;
      rd_reg_q <= (bus_sel && !bus_we && is_reg) ? reg_val : 32'd0;
    end
  end

  assign bus_rdata = rd_mem_q ? m_rd : rd_reg_q;
  assign irq       = irq_q;
endmodule

// File: rtl/matop_engine_chk.sv
module matop_engine_chk #(
  parameter int AW = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic             irq,
  input logic [1:0]       st,
  input logic [7:0][31:0] dsc,
  input logic             eng_we
);
  wire stat_wr = bus_sel && bus_we && (bus_addr == AW'(11));
  wire cmd_wr  = bus_sel && bus_we && (bus_addr == AW'(10));

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_wr) |=> irq);

  p_irq_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (st == 2'd2 || st == 2'd3));

  p_busy_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> (st == 2'd1 || st == 2'd2));

  p_eng_write_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (st == 2'd1));

  p_desc_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |=> $stable(dsc));

  p_start_by_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == 2'd1) |-> $past(cmd_wr));
endmodule

bind matop_engine matop_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq(irq), .st(st_q), .dsc(dsc_q), .eng_we(eng_we)
);

// File: tb/matop_engine_bench.sv
module matop_engine_bench;
  localparam int WIN = 1024;
  localparam int AW = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  req;
    logic [7:0]  r0, c0, r1, c1, r2, c2;
    logic [15:0] p0, p1, p2;
    logic [1:0]  st;
  } vec_t;

  // add R5, multiply R6, fit/bounds R8, shape R7, bad code R4
  localparam vec_t VECS [NV] = '{
    '{4'd1, 8'd5, 8'd3, 8'd4,  8'd3,  8'd4, 8'd3, 8'd4, 16'd100,  16'd200,  16'd300,  2'd2},
    '{4'd2, 8'd6, 8'd5, 8'd10, 8'd10, 8'd5, 8'd5, 8'd5, 16'd400,  16'd500,  16'd600,  2'd2},
    '{4'd2, 8'd8, 8'd1, 8'd1,  8'd1,  8'd1, 8'd1, 8'd1, 16'd1000, 16'd1010, 16'd1023, 2'd2},
    '{4'd2, 8'd8, 8'd3, 8'd2,  8'd2,  8'd4, 8'd3, 8'd4, 16'd16,   16'd40,   16'd60,   2'd2},
    '{4'd2, 8'd7, 8'd2, 8'd3,  8'd2,  8'd3, 8'd2, 8'd3, 16'd100,  16'd200,  16'd300,  2'd3},
    '{4'd1, 8'd7, 8'd2, 8'd2,  8'd2,  8'd2, 8'd2, 8'd3, 16'd100,  16'd200,  16'd300,  2'd3},
    '{4'd1, 8'd8, 8'd2, 8'd2,  8'd2,  8'd2, 8'd2, 8'd2, 16'd1021, 16'd200,  16'd300,  2'd3},
    '{4'd2, 8'd8, 8'd1, 8'd1,  8'd1,  8'd1, 8'd1, 8'd1, 16'd15,   16'd1000, 16'd1010, 2'd3},
    '{4'd1, 8'd7, 8'd0, 8'd3,  8'd0,  8'd3, 8'd0, 8'd3, 16'd100,  16'd200,  16'd300,  2'd3},
    '{4'd3, 8'd4, 8'd1, 8'd1,  8'd1,  8'd1, 8'd1, 8'd1, 16'd100,  16'd200,  16'd300,  2'd3},
    '{4'd2, 8'd6, 8'd1, 8'd6,  8'd6,  8'd1, 8'd1, 8'd1, 16'd700,  16'd710,  16'd720,  2'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] sh [WIN];

  matop_engine #(.WIN_WORDS(WIN)) u_matop_engine (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (a >= AW'(16)) sh[a] = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(output int cnt);
    cnt = 0;
    while (!irq && cnt < 20000) begin
      @(posedge clk); @(negedge clk);
      cnt++;
    end
  endtask

  function automatic logic [31:0] gen(input int v, input int e, input int s);
    return 32'(v) * 32'h9E3779B1 + 32'(e) * 32'h85EBCA6B + 32'(s + 1) * 32'hC2B2AE35;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] e;
    int cnt;
    vec_t t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(AW'(a), d);
      chk("R1 reg", d, 32'd0);
    end

    // R2 / R13 register access, reserved words
    wr(AW'(6), 32'hDEADBEEF);
    wr(AW'(7), 32'h0005_0007);
    rd(AW'(6), d); chk("R13 ptr3", d, 32'hDEADBEEF);
    rd(AW'(7), d); chk("R2 shape3", d, 32'h0005_0007);
    wr(AW'(8), 32'h1234_5678);
    rd(AW'(8), d); chk("R2 reserved", d, 32'd0);
    wr(AW'(13), 32'hFFFF_FFFF);
    rd(AW'(13), d); chk("R2 reserved", d, 32'd0);

    // R4 command 0 does nothing
    wr(AW'(10), 32'd0);
    rd(AW'(10), d); chk("R4 cmd0 stored", d, 32'd0);
    rd(AW'(11), d); chk("R4 cmd0 status", d, 32'd0);
    chk("R4 cmd0 irq", {31'd0, irq}, 32'd0);

    // R3 data memory access
    wr(AW'(900), 32'hA5A5_0001);
    rd(AW'(900), d); chk("R3 mem", d, 32'hA5A5_0001);

    // vector table
    for (int v = 0; v < NV; v++) begin
      t = VECS[v];
      if (t.st == 2'd2) begin
        for (int x = 0; x < int'(t.r0) * int'(t.c0); x++) wr(AW'(int'(t.p0) + x), gen(v, x, 0));
        for (int x = 0; x < int'(t.r1) * int'(t.c1); x++) wr(AW'(int'(t.p1) + x), gen(v, x, 1));
      end
      wr(AW'(0), 32'(t.p0)); wr(AW'(1), {8'd0, t.r0, 8'd0, t.c0});
      wr(AW'(2), 32'(t.p1)); wr(AW'(3), {8'd0, t.r1, 8'd0, t.c1});
      wr(AW'(4), 32'(t.p2)); wr(AW'(5), {8'd0, t.r2, 8'd0, t.c2});
      wr(AW'(10), 32'(t.op));
      if (t.st == 2'd3) begin
        chk($sformatf("R%0d irq v%0d", t.req, v), {31'd0, irq}, 32'd1);
        rd(AW'(11), d);
        chk($sformatf("R%0d status v%0d", t.req, v), d, 32'd3);
      end else begin
        wait_irq(cnt);
        chk($sformatf("R10 cycles v%0d", v), 32'(cnt),
            32'(int'(t.r2) * int'(t.c2) * (3 * ((t.op == 4'd2) ? int'(t.c0) : 1) + 1)));
        rd(AW'(11), d);
        chk($sformatf("R9 done v%0d", v), d, 32'd2);
        for (int i = 0; i < int'(t.r2); i++) begin
          for (int j = 0; j < int'(t.c2); j++) begin
            if (t.op == 4'd1) begin
              e = sh[int'(t.p0) + i * int'(t.c0) + j] + sh[int'(t.p1) + i * int'(t.c0) + j];
            end else begin
              e = 32'd0;
              for (int k = 0; k < int'(t.c0); k++)
                e = e + sh[int'(t.p0) + i * int'(t.c0) + k] * sh[int'(t.p1) + k * int'(t.c1) + j];
            end
            rd(AW'(int'(t.p2) + i * int'(t.c2) + j), d);
            chk($sformatf("R%0d elem v%0d (%0d,%0d)", t.req, v, i, j), d, e);
          end
        end
      end
      wr(AW'(11), 32'd0);
      chk($sformatf("R11 irq clear v%0d", v), {31'd0, irq}, 32'd0);
      rd(AW'(11), d);
      chk($sformatf("R11 status clear v%0d", v), d, 32'd0);
    end

    // R12 busy window behaviour during a long multiply
    wr(AW'(0), 32'd400); wr(AW'(1), 32'h000A_000A);
    wr(AW'(1), 32'h0005_000A);
    wr(AW'(2), 32'd500); wr(AW'(3), 32'h000A_0005);
    wr(AW'(4), 32'd600); wr(AW'(5), 32'h0005_0005);
    wr(AW'(10), 32'd2);
    rd(AW'(11), d); chk("R9 busy", d, 32'd1);
    wr(AW'(0), 32'd123);
    rd(AW'(0), d); chk("R12 desc write ignored", d, 32'd400);
    wr(AW'(900), 32'h0000_0055);
    rd(AW'(400), d); chk("R12 mem read zero", d, 32'd0);
    wr(AW'(11), 32'd0);
    rd(AW'(11), d); chk("R12 status write ignored", d, 32'd1);
    wait_irq(cnt);
    chk("R9 irq after busy", {31'd0, irq}, 32'd1);
    rd(AW'(900), d); chk("R12 mem write ignored", d, 32'hA5A5_0001);
    rd(AW'(11), d); chk("R9 done", d, 32'd2);
    rd(AW'(6), d); chk("R13 ptr3 kept", d, 32'hDEADBEEF);
    wr(AW'(11), 32'd0);
    chk("R11 irq clear", {31'd0, irq}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule